// File: doc/BRIEF.md
# Partial-Width Register File

This block holds sixteen 64-bit general-purpose registers. It has one write port and two read ports. Each port addresses a register through a view: the whole 64 bits, the low 32, the low 16, the low byte, or bits 15:8 (the high byte). Only the first four registers have a high-byte view.

A narrow write either clears the untouched bits or keeps them, depending on the view. A 32-bit write zeroes bits 63:32. A 16-bit or byte write keeps every bit outside its slice. A read returns the chosen slice extended to 64 bits, with zero fill or sign fill chosen per port.

A separate stack-pointer path moves register 4 down by 8 for a push and up by 8 for a pop. Both read ports see, in the same cycle, the value a register will hold after the next clock edge.

Top module: `pwrf_top`

## Requirements
- R1: After reset every register reads as zero.
- R2: View code 0 (64-bit) writes replace all 64 bits of the target register with `wr_data`.
- R3: View code 1 (32-bit) writes place `wr_data[31:0]` in bits 31:0 and force bits 63:32 to zero.
- R4: View code 2 (16-bit) writes change only bits 15:0, and view code 3 (low byte) writes change only bits 7:0; all other bits keep their value.
- R5: View code 4 (high byte) on registers 0 to 3 places `wr_data[7:0]` in bits 15:8 and keeps all other bits.
- R6: A request is illegal if it uses view code 4 on registers 4 to 15, or any view code from 5 to 7. For an illegal request `bad_req` is high in the same cycle. An illegal write changes no register. An illegal read returns zero. `bad_req` considers the write port only when `wr_en` is high, and the read ports always.
- R7: With the extend select low, a read returns the selected slice zero-extended to 64 bits. View 4 returns bits 15:8 in bits 7:0.
- R8: With the extend select high, a read of view 1, 2, 3 or 4 fills the upper bits with the slice's top bit. A view 0 read is unaffected by the select.
- R9: `sp_op` code 1 (push) lowers register 4 by 8. Code 2 (pop) raises it by 8. Codes 0 and 3 leave it alone.
- R10: When a push or pop falls in the same cycle as a legal write to register 4, the adjustment applies to the merged written value.
- R11: Reads bypass the state: each read port returns the value its register will hold after the current edge, including a same-cycle write and stack adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_view | input | 3 | Write view code |
| wr_data | input | 64 | Write value, low-aligned |
| sp_op | input | 2 | Stack adjust: 0 none, 1 push, 2 pop, 3 none |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_view | input | 3 | Read port 0 view code |
| rd0_sext | input | 1 | Read port 0 sign-extend select |
| rd0_data | output | 64 | Read port 0 result |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_view | input | 3 | Read port 1 view code |
| rd1_sext | input | 1 | Read port 1 sign-extend select |
| rd1_data | output | 64 | Read port 1 result |
| bad_req | output | 1 | Illegal view request on any active port |

## Verification
The two functions that can coincide are a port write to register 4 and a push or pop. In that cycle the stack adjustment must stack onto the merged written value, and the bypassed read must show the combined result at once. Directed cases drive a 16-bit and a 32-bit write to register 4 together with a push and with a pop. Random traffic then mixes both with reads of register 4 in every cycle. A reference model applies the merge first and the adjust second, and each read port is compared with it before the edge.

// File: rtl/pwrf_pkg.sv
package pwrf_pkg;
    localparam int XLEN = 64;

    typedef enum logic [2:0] {
        VW_Q  = 3'd0,
        VW_D  = 3'd1,
        VW_W  = 3'd2,
        VW_BL = 3'd3,
        VW_BH = 3'd4
    } view_e;

    typedef enum logic [1:0] {
        SPO_NONE = 2'd0,
        SPO_PUSH = 2'd1,
        SPO_POP  = 2'd2,
        SPO_RSVD = 2'd3
    } spop_e;

    // legal when the view is a low view, or the high byte on a capable register
    function automatic logic view_legal(input logic [2:0] view, input logic hb_capable);
        return (view <= 3'd3) || ((view == 3'd4) && hb_capable);
    endfunction
endpackage

// File: rtl/pwrf_merge.sv
module pwrf_merge
    import pwrf_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] new_val,
    input  logic [2:0]      view,
    output logic [XLEN-1:0] merged
);
    always_comb begin
        case (view)
            VW_Q:    merged = new_val;
            VW_D:    merged = {{(XLEN-32){1'b0}}, new_val[31:0]};
            VW_W:    merged = {old_val[XLEN-1:16], new_val[15:0]};
            VW_BL:   merged = {old_val[XLEN-1:8], new_val[7:0]};
            VW_BH:   merged = {old_val[XLEN-1:16], new_val[7:0], old_val[7:0]};
            default: merged = old_val;
        endcase
    end
endmodule

// File: rtl/pwrf_extract.sv
module pwrf_extract
    import pwrf_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic [2:0]      view,
    input  logic            sext,
    input  logic            legal,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] slice_v;

    always_comb begin
        case (view)
            VW_Q:    slice_v = src;
            VW_D:    slice_v = {{(XLEN-32){sext & src[31]}}, src[31:0]};
            VW_W:    slice_v = {{(XLEN-16){sext & src[15]}}, src[15:0]};
            VW_BL:   slice_v = {{(XLEN-8){sext & src[7]}}, src[7:0]};
            VW_BH:   slice_v = {{(XLEN-8){sext & src[15]}}, src[15:8]};
            default: slice_v = '0;
        endcase
        res = legal ? slice_v : '0;
    end
endmodule

// File: rtl/pwrf_sp_adj.sv
module pwrf_sp_adj
    import pwrf_pkg::*;
#(
    parameter int STEP = 8
) (
    input  logic [XLEN-1:0] base,
    input  logic [1:0]      op,
    output logic [XLEN-1:0] res
);
    always_comb begin
        case (op)
            SPO_PUSH: res = base - XLEN'(STEP);
            SPO_POP:  res = base + XLEN'(STEP);
            default:  res = base;
        endcase
    end
endmodule

// File: rtl/pwrf_top.sv
module pwrf_top
    import pwrf_pkg::*;
#(
    parameter int NREGS   = 16,
    parameter int SP_IDX  = 4,
    parameter int SP_STEP = 8,
    parameter int HB_REGS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_idx,
    input  logic [2:0]               wr_view,
    input  logic [XLEN-1:0]          wr_data,
    input  logic [1:0]               sp_op,
    input  logic [$clog2(NREGS)-1:0] rd0_idx,
    input  logic [2:0]               rd0_view,
    input  logic                     rd0_sext,
    output logic [XLEN-1:0]          rd0_data,
    input  logic [$clog2(NREGS)-1:0] rd1_idx,
    input  logic [2:0]               rd1_view,
    input  logic                     rd1_sext,
    output logic [XLEN-1:0]          rd1_data,
    output logic                     bad_req
);
    localparam int IDXW   = $clog2(NREGS);
    localparam int NRD    = 2;
    localparam logic [IDXW-1:0] SP_SEL = IDXW'(SP_IDX);

    typedef struct packed {
        logic [NREGS-1:0][XLEN-1:0] gpr;
    } rf_t;

    rf_t st_d, st_q;

    logic            wr_ok;
    logic            wr_apply;
    logic [XLEN-1:0] wr_merged;
    logic [XLEN-1:0] sp_mid;
    logic [XLEN-1:0] sp_new;

    logic [NRD-1:0][IDXW-1:0] rd_idx_a;
    logic [NRD-1:0][2:0]      rd_view_a;
    logic [NRD-1:0]           rd_sext_a;
    logic [NRD-1:0]           rd_ok_a;
    logic [NRD-1:0][XLEN-1:0] rd_res_a;

    assign wr_ok    = view_legal(wr_view, wr_idx < IDXW'(HB_REGS));
    assign wr_apply = wr_en && wr_ok;

    pwrf_merge u_merge (
        .old_val (st_q.gpr[wr_idx]),
        .new_val (wr_data),
        .view    (wr_view),
        .merged  (wr_merged)
    );

    // the stack adjust is applied on top of any same-cycle port write
    assign sp_mid = (wr_apply && (wr_idx == SP_SEL)) ? wr_merged : st_q.gpr[SP_IDX];

    pwrf_sp_adj #(.STEP(SP_STEP)) u_sp (
        .base (sp_mid),
        .op   (sp_op),
        .res  (sp_new)
    );

    always_comb begin
        st_d = st_q;
        if (wr_apply) begin
            st_d.gpr[wr_idx] = wr_merged;
        end
        st_d.gpr[SP_IDX] = sp_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx_a  = {rd1_idx, rd0_idx};
    assign rd_view_a = {rd1_view, rd0_view};
    assign rd_sext_a = {rd1_sext, rd0_sext};

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_ok_a[p] = view_legal(rd_view_a[p], rd_idx_a[p] < IDXW'(HB_REGS));
        // reads see next state: write-through bypass
        pwrf_extract u_ext (
            .src   (st_d.gpr[rd_idx_a[p]]),
            .view  (rd_view_a[p]),
            .sext  (rd_sext_a[p]),
            .legal (rd_ok_a[p]),
            .res   (rd_res_a[p])
        );
    end

    assign rd0_data = rd_res_a[0];
    assign rd1_data = rd_res_a[1];
    assign bad_req  = (wr_en && !wr_ok) || !rd_ok_a[0] || !rd_ok_a[1];
endmodule

// File: rtl/pwrf_chk.sv
module pwrf_chk
    import pwrf_pkg::*;
#(
    parameter int NREGS   = 16,
    parameter int SP_IDX  = 4,
    parameter int SP_STEP = 8,
    parameter int HB_REGS = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [$clog2(NREGS)-1:0]         wr_idx,
    input logic [2:0]                       wr_view,
    input logic [XLEN-1:0]                  wr_data,
    input logic [1:0]                       sp_op,
    input logic [$clog2(NREGS)-1:0]         rd0_idx,
    input logic [2:0]                       rd0_view,
    input logic [XLEN-1:0]                  rd0_data,
    input logic                             bad_req,
    input logic [NREGS-1:0][XLEN-1:0]       gpr_q
);
    localparam int IDXW = $clog2(NREGS);
    localparam logic [IDXW-1:0] SP_SEL = IDXW'(SP_IDX);

    // R6
    illegal_hb_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 3'd4 && wr_idx >= IDXW'(HB_REGS)) |-> bad_req);

    // R6
    illegal_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view >= 3'd4 && wr_idx >= IDXW'(HB_REGS) && wr_idx != SP_SEL)
        |=> gpr_q[$past(wr_idx)] == $past(gpr_q[wr_idx]));

    // R3
    dword_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 3'd1 && wr_idx != SP_SEL)
        |=> gpr_q[$past(wr_idx)][XLEN-1:32] == '0);

    // R4
    word_keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 3'd2 && wr_idx != SP_SEL)
        |=> gpr_q[$past(wr_idx)][XLEN-1:16] == $past(gpr_q[wr_idx][XLEN-1:16]));

    // R9
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_op == 2'd1 && !(wr_en && wr_idx == SP_SEL))
        |=> gpr_q[SP_IDX] == $past(gpr_q[SP_IDX]) - XLEN'(SP_STEP));

    // R11
    bypass_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 3'd0 && wr_idx != SP_SEL && rd0_idx == wr_idx && rd0_view == 3'd0)
        |-> rd0_data == wr_data);
endmodule

bind pwrf_top pwrf_chk #(
    .NREGS(NREGS), .SP_IDX(SP_IDX), .SP_STEP(SP_STEP), .HB_REGS(HB_REGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_view  (wr_view),
    .wr_data  (wr_data),
    .sp_op    (sp_op),
    .rd0_idx  (rd0_idx),
    .rd0_view (rd0_view),
    .rd0_data (rd0_data),
    .bad_req  (bad_req),
    .gpr_q    (st_q.gpr)
);

// File: tb/pwrf_top_tb.sv
module pwrf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [2:0]  wr_view = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  sp_op = '0;
    logic [3:0]  rd0_idx = '0;
    logic [2:0]  rd0_view = '0;
    logic        rd0_sext = 1'b0;
    logic [63:0] rd0_data;
    logic [3:0]  rd1_idx = '0;
    logic [2:0]  rd1_view = '0;
    logic        rd1_sext = 1'b0;
    logic [63:0] rd1_data;
    logic        bad_req;

    int checks = 0;
    int errors = 0;
    logic [63:0] mdl [16];
    logic [63:0] nxt [16];

    always #2.5 clk = ~clk;

    pwrf_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
        .sp_op(sp_op),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_sext(rd0_sext), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_sext(rd1_sext), .rd1_data(rd1_data),
        .bad_req(bad_req)
    );

    function automatic logic f_legal(input logic [2:0] v, input logic [3:0] idx);
        return (v <= 3'd3) || (v == 3'd4 && idx < 4'd4);
    endfunction

    function automatic logic [63:0] f_merge(input logic [63:0] o, input logic [63:0] d,
                                            input logic [2:0] v);
        logic [63:0] r;
        r = o;
        case (v)
            3'd0: r = d;
            3'd1: r = {32'h0, d[31:0]};
            3'd2: r[15:0] = d[15:0];
            3'd3: r[7:0] = d[7:0];
            3'd4: r[15:8] = d[7:0];
            default: r = o;
        endcase
        return r;
    endfunction

    function automatic logic [63:0] f_read(input logic [63:0] s, input logic [2:0] v,
                                           input logic sx, input logic ok);
        logic [63:0] r;
        if (!ok) return 64'h0;
        case (v)
            3'd0: r = s;
            3'd1: r = {{32{sx & s[31]}}, s[31:0]};
            3'd2: r = {{48{sx & s[15]}}, s[15:0]};
            3'd3: r = {{56{sx & s[7]}}, s[7:0]};
            default: r = {{56{sx & s[15]}}, s[15:8]};
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs are already driven (at a falling edge); compare before the next rising edge
    task automatic step(input string tag);
        logic ok_w;
        #1;
        for (int i = 0; i < 16; i++) nxt[i] = mdl[i];
        ok_w = f_legal(wr_view, wr_idx);
        if (wr_en && ok_w) nxt[wr_idx] = f_merge(mdl[wr_idx], wr_data, wr_view);
        if (sp_op == 2'd1) nxt[4] = nxt[4] - 64'd8;
        if (sp_op == 2'd2) nxt[4] = nxt[4] + 64'd8;
        chk({tag, " rd0"}, rd0_data, f_read(nxt[rd0_idx], rd0_view, rd0_sext, f_legal(rd0_view, rd0_idx)));
        chk({tag, " rd1"}, rd1_data, f_read(nxt[rd1_idx], rd1_view, rd1_sext, f_legal(rd1_view, rd1_idx)));
        chk({tag, " bad_req"}, {63'h0, bad_req},
            {63'h0, (wr_en && !ok_w) || !f_legal(rd0_view, rd0_idx) || !f_legal(rd1_view, rd1_idx)});
        @(posedge clk);
        for (int i = 0; i < 16; i++) mdl[i] = nxt[i];
        @(negedge clk);
    endtask

    task automatic drive(input logic we, input logic [3:0] wi, input logic [2:0] wv,
                         input logic [63:0] wd, input logic [1:0] sp,
                         input logic [3:0] a_i, input logic [2:0] a_v, input logic a_s,
                         input logic [3:0] b_i, input logic [2:0] b_v, input logic b_s);
        wr_en = we; wr_idx = wi; wr_view = wv; wr_data = wd; sp_op = sp;
        rd0_idx = a_i; rd0_view = a_v; rd0_sext = a_s;
        rd1_idx = b_i; rd1_view = b_v; rd1_sext = b_s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
        void'($urandom(32'd5511));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero
        for (int i = 0; i < 8; i++) begin
            drive(0, 0, 0, 0, 0, 4'(2*i), 0, 0, 4'(2*i+1), 0, 0);
            #1;
            chk("R1 reset rd0", rd0_data, 64'h0);
            chk("R1 reset rd1", rd1_data, 64'h0);
            step("R1");
        end

        // R2 with R11 bypass
        drive(1, 7, 0, 64'h8877665544332211, 0, 7, 0, 0, 7, 3, 0);
        #1 chk("R2 R11 bypass", rd0_data, 64'h8877665544332211);
        step("R2");

        // R3
        drive(1, 0, 0, 64'h123456789ABCDEF0, 0, 0, 0, 0, 0, 1, 0);
        step("R2");
        drive(1, 0, 1, 64'hFFFFFFFFFFFFFFFF, 0, 0, 0, 0, 0, 1, 1);
        #1 chk("R3 dword clears upper", rd0_data, 64'h00000000FFFFFFFF);
        step("R3");

        // R4
        drive(1, 7, 2, 64'h000000000000AAAA, 0, 7, 0, 0, 7, 2, 0);
        #1 chk("R4 word keep", rd0_data, 64'h887766554433AAAA);
        step("R4");
        drive(1, 7, 3, 64'hFFFFFFFFFFFFFF55, 0, 7, 0, 0, 7, 3, 0);
        #1 chk("R4 byte keep", rd0_data, 64'h887766554433AA55);
        step("R4");

        // R5
        drive(1, 2, 0, 64'hFEDCBA9876543210, 0, 2, 0, 0, 2, 4, 0);
        step("R2");
        drive(1, 2, 4, 64'h000000000000007F, 0, 2, 4, 1, 2, 0, 0);
        #1 chk("R5 high byte read", rd0_data, 64'h000000000000007F);
        chk("R5 high byte merge", rd1_data, 64'hFEDCBA9876547F10);
        step("R5");

        // R6: illegal high byte write to register 9, then illegal view code
        drive(1, 9, 4, 64'hFF, 0, 9, 0, 0, 1, 0, 0);
        #1 chk("R6 flag", {63'h0, bad_req}, 64'h1);
        step("R6");
        drive(1, 1, 6, 64'hDEAD, 0, 9, 0, 0, 1, 0, 0);
        #1 chk("R6 suppressed r9", rd0_data, 64'h0);
        chk("R6 suppressed r1", rd1_data, 64'h0);
        chk("R6 flag code6", {63'h0, bad_req}, 64'h1);
        step("R6");
        drive(0, 9, 4, 64'h0, 0, 9, 0, 0, 9, 4, 0);
        #1 chk("R6 illegal read zero", rd1_data, 64'h0);
        chk("R6 read flag", {63'h0, bad_req}, 64'h1);
        step("R6");
        drive(0, 9, 4, 64'h0, 0, 9, 0, 0, 9, 0, 0);
        #1 chk("R6 disabled write no flag", {63'h0, bad_req}, 64'h0);
        step("R6");

        // R7 / R8 on reg 7 = 887766554433AA55
        drive(0, 0, 0, 0, 0, 7, 2, 1, 7, 2, 0);
        #1 chk("R8 word sext", rd0_data, 64'hFFFFFFFFFFFFAA55);
        chk("R7 word zext", rd1_data, 64'h000000000000AA55);
        step("R8");
        drive(0, 0, 0, 0, 0, 7, 0, 1, 7, 1, 1);
        #1 chk("R8 full view unaffected", rd0_data, 64'h887766554433AA55);
        chk("R8 dword positive", rd1_data, 64'h000000004433AA55);
        step("R8");
        drive(0, 0, 0, 0, 0, 2, 4, 1, 2, 3, 1);
        step("R7 R8");

        // R9
        drive(1, 4, 0, 64'h1000, 0, 4, 0, 0, 4, 2, 0);
        step("R2");
        drive(0, 0, 0, 0, 1, 4, 0, 0, 4, 0, 0);
        #1 chk("R9 push", rd0_data, 64'h0FF8);
        step("R9");
        drive(0, 0, 0, 0, 2, 4, 0, 0, 4, 0, 0);
        #1 chk("R9 pop", rd0_data, 64'h1000);
        step("R9");
        drive(0, 0, 0, 0, 3, 4, 0, 0, 4, 0, 0);
        #1 chk("R9 reserved code", rd0_data, 64'h1000);
        step("R9");

        // R10
        drive(1, 4, 2, 64'h2000, 1, 4, 0, 0, 4, 0, 0);
        #1 chk("R10 push+write", rd0_data, 64'h1FF8);
        step("R10");
        drive(1, 4, 1, 64'hFFFFFFFF00000040, 2, 4, 0, 0, 4, 2, 0);
        #1 chk("R10 pop+write", rd0_data, 64'h48);
        step("R10");
        drive(0, 0, 0, 0, 0, 4, 0, 0, 4, 0, 0);
        #1 chk("R10 held", rd0_data, 64'h48);
        step("R10");

        // random mix, register 4 read on port 1 each cycle (R10 R11)
        for (int n = 0; n < 600; n++) begin
            logic [2:0] wv;
            logic [3:0] wi;
            wv = ($urandom % 10 == 0) ? 3'($urandom % 8) : 3'($urandom % 5);
            wi = ($urandom % 4 == 0) ? 4'd4 : 4'($urandom % 16);
            drive(1'($urandom % 3 != 0), wi, wv, {$urandom, $urandom},
                  2'($urandom % 4),
                  ($urandom % 2 == 0) ? wi : 4'($urandom % 16), 3'($urandom % 5), 1'($urandom % 2),
                  4'd4, 3'($urandom % 4), 1'($urandom % 2));
            step("R11 R10 random");
        end

        // R1: reset again and confirm
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 4, 0, 0, 7, 0, 0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
        #1 chk("R1 re-reset sp", rd0_data, 64'h0);
        chk("R1 re-reset r7", rd1_data, 64'h0);
        step("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule